// File: doc/BRIEF.md
# I/O Cycle Wait-State Stretcher

This block sits on the target side of a parallel I/O channel and lengthens bus cycles for a slow peripheral. It compares the incoming address with a base and mask set by parameters. It watches the two active-low command strobes, one for read and one for write. When a decoded access starts, it drives the shared, wired channel-ready line to its not-ready level. The drive is combinational, so no clock edge passes between the command and the pull-down.

The stretch lasts a whole number of bus clocks, taken from a 4-bit wait setting when the access begins. It ends early if the peripheral reports that it is done, and it ends at once if the command goes away. An independent hold limit of 14 clocks bounds every stretch. If the limit is reached without a done indication, a sticky timeout flag is raised, and it stays raised until a clear pulse arrives.

The open-drain line is represented by an output-enable plus a fixed low level. The pad drives low only while the enable is high.

Top module: `io_wait_stretcher`

## Requirements
- R1: In the same cycle that a decoded address (address valid high and (address & mask) == base) and at least one command strobe at 0 appear, rdy_oe rises, with no clock edge in between, provided the wait setting is not 0.
- R2: A wait setting of 0 leaves rdy_oe at 0 for the whole access.
- R3: With a wait setting N from 1 to 13 and no done indication, rdy_oe stays at 1 until N rising edges have passed since the access began, and is 0 after the N-th edge.
- R4: A wait setting above 14 behaves exactly like 14.
- R5: When periph_done is high at rising edge d of a stretch (d < N), rdy_oe is 0 after edge d.
- R6: When both command strobes return to 1, rdy_oe goes to 0 in that same cycle, even if the count has not finished.
- R7: rdy_oe never stays at 1 for more than 14 consecutive rising edges. If the 14th edge of a stretch arrives without periph_done high, timeout_flag is 1 after that edge. If periph_done is high at that edge, the flag is not set.
- R8: timeout_flag stays at 1 until timeout_clr is high at a rising edge, and is 0 after that edge. A new timeout wins over a clear.
- R9: rdy_level is always 0, so the line is only ever pulled low, never driven high.
- R10: After a release, rdy_oe stays at 0 for the rest of the access, however long the command is held.
- R11: An address outside the decoded window, or a low address-valid, never raises rdy_oe.
- R12: A read strobe alone, a write strobe alone, or both together all start a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W | Channel address |
| addr_vld | input | 1 | Address valid strobe |
| io_rd_n | input | 1 | I/O read command, active low |
| io_wr_n | input | 1 | I/O write command, active low |
| wait_cfg | input | CFG_W | Wait-state count in clocks (0 = no stretch) |
| periph_done | input | 1 | Peripheral has finished; ends the stretch at the next edge |
| timeout_clr | input | 1 | Clears the timeout flag |
| rdy_oe | output | 1 | Output enable for the ready line (1 = pull it low) |
| rdy_level | output | 1 | Level driven while enabled, always 0 |
| timeout_flag | output | 1 | Sticky hold-limit timeout indication |

## Verification
The pull-down is due in the same cycle as the decoded command, and the bench checks it 1 ns after it drives inputs at the falling edge. A stretch of N clocks ends after rising edge N. A done indication sampled at edge d ends it after edge d. The timeout flag is visible after edge 14. For all of these, the bench samples again at each following falling edge and compares against the edge count it keeps itself. A release caused by the command going away is checked 1 ns after the strobes are lifted, with no clock edge in between.

// File: rtl/iows_pkg.sv
package iows_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } hold_state_e;

endpackage

// File: rtl/iows_decode.sv
module iows_decode #(
    parameter int unsigned        ADDR_W = 10,
    parameter logic [ADDR_W-1:0]  BASE   = 10'h300,
    parameter logic [ADDR_W-1:0]  MASK   = 10'h3F8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              sel
);
    logic hit;
    logic cmd;

    always_comb begin
        hit = addr_vld && ((addr & MASK) == BASE);
        cmd = !rd_n || !wr_n;
        sel = hit && cmd;
    end

endmodule

// File: rtl/iows_clamp.sv
module iows_clamp #(
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned MAX_HOLD = 14,
    localparam int unsigned CNT_W   = $clog2(MAX_HOLD + 1)
) (
    input  logic [CFG_W-1:0] cfg_raw,
    output logic [CNT_W-1:0] cfg_eff
);
    always_comb begin
        if (int'(cfg_raw) > int'(MAX_HOLD)) begin
            cfg_eff = CNT_W'(MAX_HOLD);
        end else begin
            cfg_eff = CNT_W'(cfg_raw);
        end
    end

    always_comb begin
        p_clamp_bound_r4: assert (int'(cfg_eff) <= int'(MAX_HOLD))
            else $error("clamped wait setting above hold limit");
    end

endmodule

// File: rtl/iows_hold_ctrl.sv
module iows_hold_ctrl
    import iows_pkg::*;
#(
    parameter int unsigned MAX_HOLD = 14,
    localparam int unsigned CNT_W   = $clog2(MAX_HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [CNT_W-1:0] cfg_eff,
    input  logic             periph_done,
    output logic             rdy_oe,
    output logic             wd_fire
);
    typedef struct packed {
        hold_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } ctrl_t;

    ctrl_t cur_q;
    ctrl_t nxt_d;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        nxt_d   = cur_q;
        rdy_oe  = 1'b0;
        wd_fire = 1'b0;
        cnt_inc = {1'b0, cur_q.cnt} + 1'b1;
        case (cur_q.st)
            ST_IDLE: begin
                rdy_oe = sel && (cfg_eff != '0);
                if (sel) begin
                    nxt_d.lim = cfg_eff;
                    nxt_d.cnt = CNT_W'(1);
                    if (cfg_eff == '0 || cfg_eff == CNT_W'(1) || periph_done) begin
                        nxt_d.st = ST_DONE;
                    end else begin
                        nxt_d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                rdy_oe = sel;
                if (!sel) begin
                    nxt_d.st = ST_IDLE;
                end else if (periph_done) begin
                    nxt_d.st = ST_DONE;
                end else begin
                    nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    if (cnt_inc >= {1'b0, cur_q.lim}) begin
                        nxt_d.st = ST_DONE;
                    end
                    if (int'(cnt_inc) >= int'(MAX_HOLD)) begin
                        nxt_d.st = ST_DONE;
                        wd_fire  = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!sel) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, lim: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    p_zero_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE && cfg_eff == '0) |-> !rdy_oe)
        else $error("ready driven with zero wait setting");

    p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_HOLD && sel && periph_done) |=> !rdy_oe)
        else $error("ready still driven after peripheral done");

    p_stay_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_DONE) |-> !rdy_oe)
        else $error("ready re-driven after release");

endmodule

// File: rtl/iows_timeout_flag.sv
module iows_timeout_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_fire,
    input  logic clr,
    output logic flag
);
    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (wd_fire) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q)
        else $error("timeout flag lost without clear");

    p_fire_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |=> flag_q)
        else $error("timeout flag not set by watchdog");

endmodule

// File: rtl/io_wait_stretcher.sv
module io_wait_stretcher #(
    parameter int unsigned        ADDR_W   = 10,
    parameter logic [ADDR_W-1:0]  BASE     = 10'h300,
    parameter logic [ADDR_W-1:0]  MASK     = 10'h3F8,
    parameter int unsigned        CFG_W    = 4,
    parameter int unsigned        MAX_HOLD = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              addr_vld,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic [CFG_W-1:0]  wait_cfg,
    input  logic              periph_done,
    input  logic              timeout_clr,
    output logic              rdy_oe,
    output logic              rdy_level,
    output logic              timeout_flag
);
    localparam int unsigned CNT_W = $clog2(MAX_HOLD + 1);

    logic             sel;
    logic [CNT_W-1:0] cfg_eff;
    logic             wd_fire;

    iows_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .MASK   (MASK)
    ) u_decode (
        .addr     (io_addr),
        .addr_vld (addr_vld),
        .rd_n     (io_rd_n),
        .wr_n     (io_wr_n),
        .sel      (sel)
    );

    iows_clamp #(
        .CFG_W    (CFG_W),
        .MAX_HOLD (MAX_HOLD)
    ) u_clamp (
        .cfg_raw (wait_cfg),
        .cfg_eff (cfg_eff)
    );

    iows_hold_ctrl #(
        .MAX_HOLD (MAX_HOLD)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .cfg_eff     (cfg_eff),
        .periph_done (periph_done),
        .rdy_oe      (rdy_oe),
        .wd_fire     (wd_fire)
    );

    iows_timeout_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_fire (wd_fire),
        .clr     (timeout_clr),
        .flag    (timeout_flag)
    );

    assign rdy_level = 1'b0;

    // Consecutive-hold counter used only by the checks below.
    logic [CNT_W:0] hold_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_run_q <= '0;
        end else if (rdy_oe) begin
            hold_run_q <= hold_run_q + 1'b1;
        end else begin
            hold_run_q <= '0;
        end
    end

    p_hold_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> (int'(hold_run_q) < int'(MAX_HOLD)))
        else $error("ready held beyond the hold limit");

    p_needs_command_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> (!io_rd_n || !io_wr_n))
        else $error("ready driven without a command");

    p_needs_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> (addr_vld && ((io_addr & MASK) == BASE)))
        else $error("ready driven outside decoded window");

endmodule

// File: tb/io_wait_stretcher_tb.sv
`timescale 1ns/1ps
module io_wait_stretcher_tb;

    localparam int MAXH = 14;
    localparam logic [9:0] HIT_ADDR  = 10'h305;
    localparam logic [9:0] MISS_ADDR = 10'h310;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] io_addr;
    logic       addr_vld;
    logic       io_rd_n;
    logic       io_wr_n;
    logic [3:0] wait_cfg;
    logic       periph_done;
    logic       timeout_clr;
    logic       rdy_oe;
    logic       rdy_level;
    logic       timeout_flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    io_wait_stretcher u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_addr      (io_addr),
        .addr_vld     (addr_vld),
        .io_rd_n      (io_rd_n),
        .io_wr_n      (io_wr_n),
        .wait_cfg     (wait_cfg),
        .periph_done  (periph_done),
        .timeout_clr  (timeout_clr),
        .rdy_oe       (rdy_oe),
        .rdy_level    (rdy_level),
        .timeout_flag (timeout_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One access: start at a falling edge, hold the command for cmd_edges
    // rising edges, done_edge = edge at which periph_done is high (0 = never).
    task automatic do_access(input string req, input int cfg, input bit use_rd,
                             input bit use_wr, input int done_edge, input int cmd_edges);
        int eff;
        int rel;
        eff = (cfg > MAXH) ? MAXH : cfg;
        rel = eff;
        if (done_edge >= 1 && done_edge < rel) rel = done_edge;
        @(negedge clk);
        wait_cfg    = 4'(cfg);
        io_addr     = HIT_ADDR;
        addr_vld    = 1'b1;
        io_rd_n     = !use_rd;
        io_wr_n     = !use_wr;
        periph_done = (done_edge == 1);
        #1 chk({req, " start"}, rdy_oe, rel > 0);
        for (int k = 1; k <= cmd_edges; k++) begin
            @(negedge clk);
            periph_done = (done_edge == k + 1);
            #1 chk({req, " hold"}, rdy_oe, k < rel);
        end
        @(negedge clk);
        io_rd_n     = 1'b1;
        io_wr_n     = 1'b1;
        periph_done = 1'b0;
        #1 chk("R6 release on command end", rdy_oe, 1'b0);
        addr_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R9 reset rdy_oe", rdy_oe, 1'b0);
        chk("R9 level low", rdy_level, 1'b0);
        chk("R8 reset flag", timeout_flag, 1'b0);
    endtask

    task automatic t_miss;
        @(negedge clk);
        wait_cfg = 4'd5; io_addr = MISS_ADDR; addr_vld = 1'b1; io_rd_n = 1'b0;
        #1 chk("R11 miss address", rdy_oe, 1'b0);
        @(negedge clk);
        io_addr = HIT_ADDR; addr_vld = 1'b0;
        #1 chk("R11 address not valid", rdy_oe, 1'b0);
        @(negedge clk);
        io_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_counts;
        do_access("R2 zero wait", 0, 1'b1, 1'b0, 0, 4);
        do_access("R3 one wait read", 1, 1'b1, 1'b0, 0, 3);
        do_access("R3 three wait write", 3, 1'b0, 1'b1, 0, 5);
        do_access("R1 R3 seven wait read", 7, 1'b1, 1'b0, 0, 9);
        do_access("R12 both strobes", 4, 1'b1, 1'b1, 0, 6);
        do_access("R10 stays released", 2, 1'b0, 1'b1, 0, 8);
        chk("R7 no timeout on normal count", timeout_flag, 1'b0);
    endtask

    task automatic t_done_and_abort;
        do_access("R5 done at edge 2", 8, 1'b1, 1'b0, 2, 6);
        do_access("R5 done at edge 1", 8, 1'b0, 1'b1, 1, 3);
        do_access("R6 early command end", 10, 1'b1, 1'b0, 0, 3);
        chk("R7 no timeout after abort", timeout_flag, 1'b0);
    endtask

    task automatic t_timeout;
        do_access("R7 done at limit edge", 14, 1'b1, 1'b0, 14, 16);
        chk("R7 done at limit no flag", timeout_flag, 1'b0);
        do_access("R4 clamp 15 to 14", 15, 1'b1, 1'b0, 0, 16);
        chk("R7 flag after limit", timeout_flag, 1'b1);
        do_access("R8 another access", 2, 1'b1, 1'b0, 0, 3);
        chk("R8 flag sticky", timeout_flag, 1'b1);
        @(negedge clk);
        timeout_clr = 1'b1;
        @(negedge clk);
        timeout_clr = 1'b0;
        #1 chk("R8 flag cleared", timeout_flag, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; addr_vld = 1'b0; io_rd_n = 1'b1; io_wr_n = 1'b1;
        wait_cfg = '0; periph_done = 1'b0; timeout_clr = 1'b0;
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_miss();
        t_counts();
        t_done_and_abort();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule